// File: doc/BRIEF.md
# Two-Wire Register-Pair Slave

This block is a slave on a two-wire serial bus (I2C-style, SCL and SDA, 7-bit addressing). It gives a host access to an 8-bit-addressed register space organised as 16-bit register pairs. The high byte of a pair sits at the even address and the low byte at the odd address that follows it. The host first sends a pointer byte. It then streams data bytes in, or after a repeated START streams them out. The pointer advances by one after every byte.

Both bus lines are sampled by the system clock and are not filtered. SDA is driven only through an open-drain enable. Writes reach the register file only as complete 16-bit pairs, and each pair is checked against a per-pair writable attribute. On reads, the low half of a pair is frozen at the moment its high half is sent. This makes the host always see a coherent pair.

Top module: `i2cp_regpair_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and `wr_en` is 0.
- R2: The block acknowledges only the address byte whose upper seven bits equal the parameter `SLV_ADDR` (default 7'h36; bit 0 is R/W, with 1 meaning read). A different address is not acknowledged. The block then drives nothing and writes nothing until the next START.
- R3: In a write transaction the slave acknowledges the pointer byte and every data byte. Each data byte is received most significant bit first, and the pointer advances by one after each byte.
- R4: A register write is a single-cycle `wr_en` pulse with `wr_pair` = address >> 1 and `wr_data` = {high byte, low byte}. It fires only after the low (odd-address) byte of a pair is acknowledged, and only if that pair's high (even-address) byte came earlier in the same transaction. A lone low byte writes nothing.
- R5: A pair whose even address is above 0x4F is never written.
- R6: A pair for which `wr_ok` is 0 while `pair_idx` selects it is never written.
- R7: A high byte with no low byte after it, a byte cut off before its eighth bit, or a high byte followed by STOP or repeated START all leave storage unchanged.
- R8: After a repeated START and the address with R/W=1, the slave drives the byte at the pointer most significant bit first. It goes on with the next address for each master ACK.
- R9: During each master acknowledge bit the slave releases SDA. After a master NACK it keeps SDA released.
- R10: Once a read passes address 0xFF, every further byte is 0xFF.
- R11: When a high byte is sent, the low byte of the same pair is captured. If the low byte is read next in that transaction, it returns the captured value even if the register file has changed in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| pair_idx | output | ADDR_W-1 | Register pair currently addressed by the pointer |
| rd_pair | input | 16 | Contents of pair `pair_idx`, {high, low} |
| wr_ok | input | 1 | 1 when pair `pair_idx` is writable |
| wr_en | output | 1 | Single-cycle pair write strobe |
| wr_pair | output | ADDR_W-1 | Pair index written |
| wr_data | output | 16 | Pair data written, {high, low} |

## Verification
Two actions share a single clock edge. In one, the pointer advances at the same edge where a byte is loaded for transmission and the low half of its pair is captured. In the other, the pair strobe fires at the edge where the pointer steps past the low byte. The bench provokes the first by changing the register file between the high and low byte of one read. It judges the result by whether the old low byte comes back. The second is judged by counting strobes and reading pairs back after bursts that start at odd addresses, cross 0x4F, or are broken by STOP, repeated START or a short byte.

// File: rtl/i2cp_pkg.sv
// Shared types for the two-wire register-pair slave.
package i2cp_pkg;
    typedef enum logic [3:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ADDR_ACK,
        LS_PTR,
        LS_PTR_ACK,
        LS_WDATA,
        LS_WDATA_ACK,
        LS_RDATA,
        LS_RACK
    } link_state_t;
endpackage

// File: rtl/i2cp_bus_cond.sv
// Synchronises SCL/SDA into the clock domain and flags clock edges,
// START and STOP. Assumes the system clock is several times faster
// than SCL; the lines idle high, so the synchronisers reset to 1.
module i2cp_bus_cond #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [SYNC_LEN-1:0] scl_sync, sda_sync;
    logic scl_q, sda_q, scl_s;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_LEN-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_LEN-2:0], sda_i};
            scl_q    <= scl_sync[SYNC_LEN-1];
            sda_q    <= sda_sync[SYNC_LEN-1];
        end
    end

    assign scl_s     = scl_sync[SYNC_LEN-1];
    assign sda_s     = sda_sync[SYNC_LEN-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cp_link.sv
// Bit/byte engine: address match, pointer byte, write bytes, read bytes
// and acknowledge cycles. Emits registered one-cycle events for the
// register port. Assumes tx_byte is valid whenever a byte is loaded.
module i2cp_link
    import i2cp_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h36
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_s,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output logic       idle,
    output logic       ptr_load,
    output logic       byte_wr,
    output logic       byte_rd,
    output logic [7:0] rx_byte
);
    link_state_t state;
    logic [7:0]  shreg;
    logic [3:0]  cnt;
    logic        rw, nack;

    // Bus state machine, shift register and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LS_IDLE;
            shreg    <= '1;
            cnt      <= '0;
            rw       <= 1'b0;
            nack     <= 1'b1;
            ptr_load <= 1'b0;
            byte_wr  <= 1'b0;
            byte_rd  <= 1'b0;
        end else begin
            ptr_load <= 1'b0;
            byte_wr  <= 1'b0;
            byte_rd  <= 1'b0;
            if (start_det) begin
                state <= LS_ADDR;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= LS_IDLE;
            end else begin
                case (state)
                    LS_ADDR, LS_PTR, LS_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == LS_ADDR) begin
                                if (shreg[7:1] == SLV_ADDR) begin
                                    rw    <= shreg[0];
                                    state <= LS_ADDR_ACK;
                                end else begin
                                    state <= LS_IDLE;
                                end
                            end else if (state == LS_PTR) begin
                                ptr_load <= 1'b1;
                                state    <= LS_PTR_ACK;
                            end else begin
                                state <= LS_WDATA_ACK;
                            end
                        end
                    end
                    LS_ADDR_ACK: if (scl_fall) begin
                        if (rw) begin
                            shreg   <= tx_byte;
                            byte_rd <= 1'b1;
                            state   <= LS_RDATA;
                        end else begin
                            state <= LS_PTR;
                        end
                    end
                    LS_PTR_ACK: if (scl_fall) state <= LS_WDATA;
                    LS_WDATA_ACK: if (scl_fall) begin
                        byte_wr <= 1'b1;
                        state   <= LS_WDATA;
                    end
                    LS_RDATA: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt   <= '0;
                            state <= LS_RACK;
                        end else begin
                            shreg <= {shreg[6:0], 1'b1};
                            cnt   <= cnt + 4'd1;
                        end
                    end
                    LS_RACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (!nack) begin
                                shreg   <= tx_byte;
                                byte_rd <= 1'b1;
                                state   <= LS_RDATA;
                            end else begin
                                state <= LS_IDLE;
                            end
                        end
                    end
                    default: state <= LS_IDLE;
                endcase
            end
        end
    end

    assign sda_oe  = (state == LS_ADDR_ACK) || (state == LS_PTR_ACK) ||
                     (state == LS_WDATA_ACK) || (state == LS_RDATA && !shreg[7]);
    assign idle    = (state == LS_IDLE);
    assign rx_byte = shreg;
endmodule

// File: rtl/i2cp_pair_port.sv
// Pointer, write staging and read shadow. Turns byte events into
// 16-bit pair writes and supplies the next byte to transmit. Assumes
// rd_pair and wr_ok describe pair pair_idx in the same cycle.
module i2cp_pair_port #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] WR_LAST = 8'h4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ptr_load,
    input  logic              byte_wr,
    input  logic              byte_rd,
    input  logic [7:0]        rx_byte,
    input  logic [15:0]       rd_pair,
    input  logic              wr_ok,
    output logic [ADDR_W-2:0] pair_idx,
    output logic [7:0]        tx_byte,
    output logic              wr_en,
    output logic [ADDR_W-2:0] wr_pair,
    output logic [15:0]       wr_data
);
    localparam int PAIR_W = ADDR_W - 1;

    logic [ADDR_W:0]   ptr;
    logic              ptr_ovf;
    logic [7:0]        stage, shadow;
    logic [PAIR_W-1:0] stage_idx, shadow_idx;
    logic              stage_v, shadow_v;

    assign ptr_ovf  = ptr[ADDR_W];
    assign pair_idx = ptr[ADDR_W-1:1];

    // Byte to send: all ones past the top, shadowed low half when valid.
    always_comb begin
        if (ptr_ovf)
            tx_byte = 8'hFF;
        else if (!ptr[0])
            tx_byte = rd_pair[15:8];
        else if (shadow_v && shadow_idx == pair_idx)
            tx_byte = shadow;
        else
            tx_byte = rd_pair[7:0];
    end

    // Pointer: loaded from the pointer byte, saturating advance per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_load)
            ptr <= {1'b0, rx_byte};
        else if ((byte_wr || byte_rd) && !ptr_ovf)
            ptr <= ptr + 1'b1;
    end

    // Staging of high bytes, pair commit, and low-byte shadow capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage      <= '0;
            stage_idx  <= '0;
            stage_v    <= 1'b0;
            shadow     <= '0;
            shadow_idx <= '0;
            shadow_v   <= 1'b0;
            wr_en      <= 1'b0;
            wr_pair    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (clr) begin
                stage_v  <= 1'b0;
                shadow_v <= 1'b0;
            end else if (byte_wr) begin
                if (!ptr[0]) begin
                    stage     <= rx_byte;
                    stage_idx <= pair_idx;
                    stage_v   <= !ptr_ovf && (ptr[ADDR_W-1:0] <= WR_LAST) && wr_ok;
                end else begin
                    stage_v <= 1'b0;
                    if (stage_v && stage_idx == pair_idx && !ptr_ovf) begin
                        wr_en   <= 1'b1;
                        wr_pair <= pair_idx;
                        wr_data <= {stage, rx_byte};
                    end
                end
            end else if (byte_rd && !ptr[0] && !ptr_ovf) begin
                shadow     <= rd_pair[7:0];
                shadow_idx <= pair_idx;
                shadow_v   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cp_regpair_slave.sv
// Top level of the two-wire register-pair slave: line conditioning,
// bus engine and register-pair port. SDA is open drain (sda_oe=1
// pulls low); no clock stretching is performed.
module i2cp_regpair_slave #(
    parameter logic [6:0]        SLV_ADDR = 7'h36,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WR_LAST  = 8'h4F,
    parameter int                SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-2:0] pair_idx,
    input  logic [15:0]       rd_pair,
    input  logic              wr_ok,
    output logic              wr_en,
    output logic [ADDR_W-2:0] wr_pair,
    output logic [15:0]       wr_data
);
    logic scl_rise, scl_fall, bus_start, bus_stop, sda_s;
    logic link_idle, ptr_load, byte_wr, byte_rd;
    logic [7:0] rx_byte, tx_byte;

    i2cp_bus_cond #(.SYNC_LEN(SYNC_LEN)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(bus_start), .stop_det(bus_stop), .sda_s(sda_s)
    );

    i2cp_link #(.SLV_ADDR(SLV_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(bus_start), .stop_det(bus_stop), .sda_s(sda_s),
        .tx_byte(tx_byte), .sda_oe(sda_oe), .idle(link_idle),
        .ptr_load(ptr_load), .byte_wr(byte_wr), .byte_rd(byte_rd),
        .rx_byte(rx_byte)
    );

    i2cp_pair_port #(.ADDR_W(ADDR_W), .WR_LAST(WR_LAST)) u_port (
        .clk(clk), .rst_n(rst_n), .clr(bus_start | bus_stop),
        .ptr_load(ptr_load), .byte_wr(byte_wr), .byte_rd(byte_rd),
        .rx_byte(rx_byte), .rd_pair(rd_pair), .wr_ok(wr_ok),
        .pair_idx(pair_idx), .tx_byte(tx_byte), .wr_en(wr_en),
        .wr_pair(wr_pair), .wr_data(wr_data)
    );
endmodule

// File: rtl/i2cp_regpair_chk.sv
// Property checker for the register-pair slave, bound to the top.
module i2cp_regpair_chk #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] WR_LAST = 8'h4F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [ADDR_W-2:0] wr_pair,
    input logic              wr_ok,
    input logic              link_idle,
    input logic              bus_start,
    input logic              bus_stop
);
    AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({wr_pair, 1'b0} <= WR_LAST));                          // R5
    AST_WR_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(wr_ok));                                          // R6
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                                // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        link_idle |-> !sda_oe);                                           // R2
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !sda_oe);                                           // R9
    AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !wr_en);                                             // R7
endmodule

bind i2cp_regpair_slave i2cp_regpair_chk #(.ADDR_W(ADDR_W), .WR_LAST(WR_LAST)) chk_i (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_en(wr_en),
    .wr_pair(wr_pair), .wr_ok(wr_ok), .link_idle(link_idle),
    .bus_start(bus_start), .bus_stop(bus_stop)
);

// File: tb/i2cp_regpair_slave_tb_top.sv
module i2cp_regpair_slave_tb_top;
    localparam int Q = 5;
    localparam logic [7:0] AW = 8'h6C;
    localparam logic [7:0] AR = 8'h6D;
    // {pad, stored, address, value}
    localparam logic [31:0] VEC [0:4] = '{
        {7'd0, 1'b1, 8'h0A, 16'h1234},
        {7'd0, 1'b0, 8'h02, 16'hBEEF},
        {7'd0, 1'b1, 8'h4E, 16'hA55A},
        {7'd0, 1'b0, 8'h50, 16'h0F0F},
        {7'd0, 1'b1, 8'h30, 16'h8001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic sda_oe, wr_en, wr_ok, sda_line;
    logic [6:0] pair_idx, wr_pair;
    logic [15:0] rd_pair, wr_data;
    logic [15:0] mem [128];
    logic poke_req = 1'b0;
    logic [6:0] poke_idx = '0;
    logic [15:0] poke_val = '0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    int total = 0, bad = 0, wr_cnt = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_pair  = mem[pair_idx];
    assign wr_ok    = (pair_idx >= 7'd2);

    i2cp_regpair_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .pair_idx(pair_idx), .rd_pair(rd_pair),
        .wr_ok(wr_ok), .wr_en(wr_en), .wr_pair(wr_pair), .wr_data(wr_data)
    );

    function automatic logic [15:0] init_val(input int i);
        logic [7:0] a;
        a = 8'(i * 2);
        return {a ^ 8'hC3, (a | 8'h01) ^ 8'h3C};
    endfunction

    // Register file model: reset contents, write strobe, bench pokes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
        end else begin
            if (wr_en) begin
                mem[wr_pair] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (poke_req) mem[poke_idx] <= poke_val;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b0; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
        end
        sda_m = nack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic open_ptr(input logic [7:0] addr);
        logic ack;
        bus_start();
        send_byte(AW, ack);   chk("R2 own address ack", 32'(ack), 1);
        send_byte(addr, ack); chk("R3 pointer ack", 32'(ack), 1);
    endtask

    task automatic wr_burst(input logic [7:0] addr, input int n);
        logic ack;
        open_ptr(addr);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack); chk("R3 data ack", 32'(ack), 1);
        end
        bus_stop();
    endtask

    task automatic rd_burst(input logic [7:0] addr, input int n);
        logic ack;
        open_ptr(addr);
        bus_rstart();
        send_byte(AR, ack); chk("R8 read address ack", 32'(ack), 1);
        for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic [15:0] e;
        int c0;
        tick(5);
        chk("R1 sda_oe in reset", 32'(sda_oe), 0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 sda_oe after reset", 32'(sda_oe), 0);
        chk("R1 wr_en after reset", 32'(wr_en), 0);

        // Vector table: write one pair, read it back.
        for (int v = 0; v < 5; v++) begin
            wbuf[0] = VEC[v][15:8]; wbuf[1] = VEC[v][7:0];
            wr_burst(VEC[v][23:16], 2);
            rd_burst(VEC[v][23:16], 2);
            e = VEC[v][24] ? VEC[v][15:0] : init_val(int'(VEC[v][23:17]));
            chk("R4 R5 R6 table readback", {16'h0, rbuf[0], rbuf[1]}, {16'h0, e});
        end

        // R2: foreign address NACKed, following byte ignored.
        c0 = wr_cnt;
        bus_start();
        send_byte(8'hA0, ack); chk("R2 foreign address nack", 32'(ack), 0);
        send_byte(8'h10, ack); chk("R2 ignored until START", 32'(ack), 0);
        chk("R2 no drive while ignored", 32'(sda_oe), 0);
        bus_stop();
        chk("R2 no write", wr_cnt - c0, 0);

        // R3/R4/R8: two-pair burst, read back in one transaction.
        c0 = wr_cnt;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_burst(8'h10, 4);
        chk("R4 two strobes", wr_cnt - c0, 2);
        rd_burst(8'h10, 4);
        chk("R8 burst read", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h11223344);

        // R4: burst starting on a low byte writes only the following pair.
        c0 = wr_cnt;
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        wr_burst(8'h15, 3);
        chk("R4 lone low byte dropped", wr_cnt - c0, 1);
        rd_burst(8'h14, 4);
        chk("R4 odd start readback", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]},
            {init_val(10), 16'hBBCC});

        // R5: burst crossing 0x4F.
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        wr_burst(8'h4E, 4);
        rd_burst(8'h4E, 4);
        chk("R5 write limit", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, {16'h0102, init_val(40)});

        // R7: high byte only.
        wbuf[0] = 8'h77;
        wr_burst(8'h20, 1);
        rd_burst(8'h20, 2);
        chk("R7 half pair", {16'h0, rbuf[0], rbuf[1]}, {16'h0, init_val(16)});

        // R7: low byte cut short by STOP.
        open_ptr(8'h22);
        send_byte(8'h99, ack);
        send_bits(8'h5A, 5);
        bus_stop();
        rd_burst(8'h22, 2);
        chk("R7 short byte", {16'h0, rbuf[0], rbuf[1]}, {16'h0, init_val(17)});

        // R7: repeated START between high and low byte.
        open_ptr(8'h24);
        send_byte(8'h66, ack);
        bus_rstart();
        send_byte(AW, ack);
        send_byte(8'h25, ack);
        send_byte(8'h55, ack);
        bus_stop();
        rd_burst(8'h24, 2);
        chk("R7 repeated START discards", {16'h0, rbuf[0], rbuf[1]}, {16'h0, init_val(18)});

        // R10: read past the top of the space.
        rd_burst(8'hFE, 4);
        chk("R10 past 0xFF", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, {init_val(127), 16'hFFFF});

        // R11 and R9: pair changes between high and low byte of one read.
        open_ptr(8'h40);
        bus_rstart();
        send_byte(AR, ack);
        recv_byte(1'b0, b);
        chk("R11 high byte", 32'(b), 32'(init_val(32) >> 8));
        poke_idx = 7'd32; poke_val = 16'h0000; poke_req = 1'b1; tick(1); poke_req = 1'b0;
        recv_byte(1'b1, b);
        chk("R11 low byte from capture", 32'(b), 32'(init_val(32) & 16'h00FF));
        chk("R9 released after NACK", 32'(sda_oe), 0);
        scl = 1'b1; tick(2 * Q);
        chk("R9 still released", 32'(sda_oe), 0);
        scl = 1'b0; tick(Q);
        bus_stop();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule